// File: doc/BRIEF.md
# Paced Parallel Pin Driver

This block drives an 8-pin parallel bus from a stream of bytes. Bytes arrive on a valid/ready write channel and wait in a single holding register. A byte moves onto the pins only when one is waiting and a programmable rate divider fires its tick. After each update the block drives an active-low write strobe, so external logic can latch the new value. The data is set up before the strobe falls and is held after the strobe rises. A direction mask picks which pins are driven. The other pins are left undriven and act as inputs.

The pins can also be read. A single-cycle read request starts a read. The block pulses an active-low read strobe, takes the pin levels through a two-flop synchroniser and returns them with a one-cycle valid flag. A mode register controls the whole port. Writing 0x01 enables it, and any other value puts it back into its idle, reset-like state.

Back-pressure rules for the write channel: `wr_ready` is high only while the port is enabled and its holding register is empty. A byte moves on a clock edge where both `wr_valid` and `wr_ready` are high. The producer must keep `wr_valid` and `wr_data` steady until that edge. While `wr_ready` is low the offered byte is not taken, and the byte already waiting stays unchanged.

Top module: `bitbang_port`

## Requirements
- R1: While enabled, `pin_oe[i]` equals `dir_mask[i]`, where 1 means the pin is driven. While idle, `pin_oe` is all zero.
- R2: `pin_out` changes only on a clock edge where a byte is waiting and the rate tick is present. The tick recurs every `rate_div`+1 clocks, and the first tick comes `rate_div` clocks after enabling. Two bytes written back-to-back therefore appear `rate_div`+1 clocks apart, provided that spacing exceeds 4 clocks.
- R3: With no new byte accepted, `pin_out` keeps its last value and `wr_strobe_n` stays high indefinitely.
- R4: `wr_ready` is high exactly when the port is enabled and the holding register is empty. A byte offered while `wr_ready` is low is not taken, and the waiting byte is kept.
- R5: After an update, `pin_out` takes its new value one clock before `wr_strobe_n` falls. `wr_strobe_n` stays low for exactly two clocks, and `pin_out` does not change until at least one clock after it rises.
- R6: While enabled, a one-cycle `rd_req` makes `rd_strobe_n` go low on the next edge, for two clocks. `rd_valid` is then high for one clock, three edges after the request. At that point `rd_data` equals `pin_in`, provided `pin_in` was steady for the three clocks before the request.
- R7: Writing `mode_val` with `mode_wr` high takes effect on the next edge. The value 0x01 enables the port. Any other value, including 0x00 and 0x04, makes it idle. When idle, the waiting byte is discarded, `pin_out` becomes 0x00, both strobes are high, `wr_ready` is low and `rd_req` starts no read.
- R8: After reset the port is idle, as in R7. `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load `mode_val` into the mode register |
| mode_val | input | 8 | Mode value; 0x01 enables, anything else idles |
| rate_div | input | 16 | Tick period minus one, in clocks |
| dir_mask | input | 8 | Per-pin direction, 1 = output |
| wr_valid | input | 1 | Write channel: byte offered |
| wr_ready | output | 1 | Write channel: holding register free |
| wr_data | input | 8 | Write channel: byte |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Output value to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| wr_strobe_n | output | 1 | Active-low strobe after each output update |
| rd_strobe_n | output | 1 | Active-low strobe during a pin read |
| rd_req | input | 1 | One-cycle request to sample the pins |
| rd_valid | output | 1 | One-cycle flag: `rd_data` holds a sample |
| rd_data | output | 8 | Sampled pin levels |

## Verification
The properties assume a few things about the inputs. `rate_div` is not changed while a tick is due. The mode is not switched in the middle of a strobe. The producer holds its byte steady while `wr_ready` is low. The stimulus writes new rate values only while the port is idle or while the strobes are quiet. It switches modes only after each strobe has finished, and it drives all inputs at the falling clock edge. Read requests are issued only after `pin_in` has been steady for several clocks, so the synchroniser never sees a changing input.

// File: rtl/bbp_pkg.sv
`timescale 1ns/1ps
package bbp_pkg;
  // Mode register code that enables the port; every other code idles it.
  localparam logic [7:0] MODE_ASYNC = 8'h01;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_LOW,
    SQ_HOLD
  } seq_e;

  typedef enum logic {
    RS_IDLE,
    RS_LOW
  } rd_e;
endpackage

// File: rtl/bbp_rate_div.sv
`timescale 1ns/1ps
module bbp_rate_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // Reload counter: counts div..0, then reloads. Held at div while idle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= div;
    end else if (cnt == '0) begin
      cnt <= div;
    end else begin
      cnt <= cnt - DIV_W'(1);
    end
  end

  assign tick = en && (cnt == '0);

  // R2: with a period above one clock, ticks never come back-to-back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/bbp_out_seq.sv
`timescale 1ns/1ps
module bbp_out_seq
  import bbp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STB_LOW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] out_data,
  output logic              strobe_n
);
  localparam int CNT_W = $clog2(STB_LOW + 1);

  seq_e              state;
  logic [CNT_W-1:0]  lcnt;
  logic              pend;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] out_q;
  logic              load;
  logic              accept;

  assign in_ready = en && !pend;
  assign accept   = in_valid && in_ready;
  assign load     = en && (state == SQ_IDLE) && pend && tick;

  // Holding register and output register
  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      pend   <= 1'b0;
      pend_q <= '0;
      out_q  <= '0;
    end else begin
      if (load) begin
        out_q <= pend_q;
        pend  <= 1'b0;
      end
      if (accept) begin
        pend   <= 1'b1;
        pend_q <= in_data;
      end
    end
  end

  // Strobe sequencer: setup clock, STB_LOW low clocks, hold clock
  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state    <= SQ_IDLE;
      lcnt     <= '0;
      strobe_n <= 1'b1;
    end else begin
      case (state)
        SQ_IDLE: if (load) state <= SQ_SETUP;
        SQ_SETUP: begin
          state    <= SQ_LOW;
          lcnt     <= CNT_W'(STB_LOW - 1);
          strobe_n <= 1'b0;
        end
        SQ_LOW: begin
          if (lcnt == '0) begin
            state    <= SQ_HOLD;
            strobe_n <= 1'b1;
          end else begin
            lcnt <= lcnt - CNT_W'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign out_data = out_q;

  // R2: an enabled port changes its pins only after a tick with a byte waiting
  p_update_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && out_q != $past(out_q)) |-> $past(tick && pend));
  // R4: a waiting byte is neither lost nor overwritten until it is loaded
  p_pend_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pend && !load) |=> (pend && $stable(pend_q)));
  // R5: data is already settled when the strobe falls
  p_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> $stable(out_q));
  // R5: the strobe is low for at least two clocks
  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |=> !strobe_n);
  // R5: data holds while the strobe is low
  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && $past(!strobe_n)) |-> $stable(out_q));
endmodule

// File: rtl/bbp_in_sample.sv
`timescale 1ns/1ps
module bbp_in_sample
  import bbp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STB_LOW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] pins,
  input  logic              req,
  output logic              strobe_n,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data
);
  localparam int CNT_W = $clog2(STB_LOW + 1);

  logic [DATA_W-1:0] sync1;
  logic [DATA_W-1:0] sync2;
  rd_e               state;
  logic [CNT_W-1:0]  cnt;

  // Two-flop synchroniser on the pad inputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state     <= RS_IDLE;
      cnt       <= '0;
      strobe_n  <= 1'b1;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      smp_valid <= 1'b0;
      case (state)
        RS_IDLE: begin
          if (req) begin
            state    <= RS_LOW;
            strobe_n <= 1'b0;
            cnt      <= CNT_W'(STB_LOW - 1);
          end
        end
        default: begin
          if (cnt == '0) begin
            state     <= RS_IDLE;
            strobe_n  <= 1'b1;
            smp_valid <= 1'b1;
            smp_data  <= sync2;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R6: a sample is returned only at the end of a read strobe
  p_rd_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(!strobe_n));
  // R6: the read strobe lasts at least two clocks
  p_rd_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |=> !strobe_n);
endmodule

// File: rtl/bitbang_port.sv
`timescale 1ns/1ps
module bitbang_port
  import bbp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 16,
  parameter int STB_LOW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [7:0]        mode_val,
  input  logic [DIV_W-1:0]  rate_div,
  input  logic [DATA_W-1:0] dir_mask,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic              wr_strobe_n,
  output logic              rd_strobe_n,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [7:0] mode_q;
  logic       en;
  logic       tick;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr) mode_q <= mode_val;
  end

  assign en     = (mode_q == MODE_ASYNC);
  assign pin_oe = en ? dir_mask : '0;

  bbp_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .div  (rate_div),
    .tick (tick)
  );

  bbp_out_seq #(.DATA_W(DATA_W), .STB_LOW(STB_LOW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tick    (tick),
    .in_valid(wr_valid),
    .in_ready(wr_ready),
    .in_data (wr_data),
    .out_data(pin_out),
    .strobe_n(wr_strobe_n)
  );

  bbp_in_sample #(.DATA_W(DATA_W), .STB_LOW(STB_LOW)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pins     (pin_in),
    .req      (rd_req),
    .strobe_n (rd_strobe_n),
    .smp_valid(rd_valid),
    .smp_data (rd_data)
  );

  // R7: one edge after the port is seen idle, both strobes and the pins are quiet
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (wr_strobe_n && rd_strobe_n && pin_out == '0 && !rd_valid));
  // R1: undriven pins never carry an output enable
  p_oe_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_mask) == '0);
endmodule

// File: tb/tb_bitbang_port.sv
`timescale 1ns/1ps
module tb_bitbang_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {rate_div, dir_mask, data, pin_in}
  localparam logic [39:0] VEC [0:NVEC-1] = '{
    {16'd3,  8'hFF, 8'h55, 8'h00},
    {16'd0,  8'h0F, 8'hAA, 8'h3C},
    {16'd7,  8'hF0, 8'h01, 8'hFF},
    {16'd12, 8'h81, 8'h80, 8'hA5},
    {16'd1,  8'h00, 8'h7E, 8'h5A},
    {16'd20, 8'h3C, 8'hC3, 8'h81}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_val = '0;
  logic [15:0] rate_div = 16'd3;
  logic [7:0]  dir_mask = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;
  logic        wr_strobe_n;
  logic        rd_strobe_n;
  logic        rd_req = 1'b0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitbang_port dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .rate_div(rate_div), .dir_mask(dir_mask), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .wr_strobe_n(wr_strobe_n),
    .rd_strobe_n(rd_strobe_n), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  // Strobe monitor, sampled at falling edges
  logic       prev_wr = 1'b1;
  logic [7:0] prev_pin = '0;
  logic [7:0] pin_at_fall = '0;
  int low_len = 0, fall_count = 0, setup_bad = 0, width_bad = 0, hold_bad = 0;
  int fall_cyc_last = 0, fall_cyc_prev = 0;

  always @(negedge clk) begin
    if (prev_wr && !wr_strobe_n) begin
      fall_count    <= fall_count + 1;
      fall_cyc_prev <= fall_cyc_last;
      fall_cyc_last <= cyc;
      if (pin_out != prev_pin) setup_bad <= setup_bad + 1;
      pin_at_fall <= pin_out;
      low_len     <= 1;
    end else if (!prev_wr && !wr_strobe_n) begin
      low_len <= low_len + 1;
    end else if (!prev_wr && wr_strobe_n) begin
      if (low_len != 2) width_bad <= width_bad + 1;
      if (pin_out != pin_at_fall) hold_bad <= hold_bad + 1;
    end
    prev_wr  <= wr_strobe_n;
    prev_pin <= pin_out;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] v);
    mode_val = v;
    mode_wr  = 1'b1;
    @(negedge clk);
    mode_wr  = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    int guard = 0;
    wr_data  = b;
    wr_valid = 1'b1;
    while (!wr_ready && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_falls(input int target);
    int guard = 0;
    while (fall_count < target && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    int seen = 0;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(req, "rd_strobe_n low after request", {31'b0, rd_strobe_n}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    seen = rd_valid;
    chk(req, "rd_valid three edges after request", seen, 32'd1);
    chk(req, "rd_data", {24'b0, rd_data}, {24'b0, exp});
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog (R2/R6) actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "pin_out", {24'b0, pin_out}, 32'h0);
    chk("R8", "pin_oe", {24'b0, pin_oe}, 32'h0);
    chk("R8", "wr_ready", {31'b0, wr_ready}, 32'd0);
    chk("R8", "strobes", {30'b0, wr_strobe_n, rd_strobe_n}, 32'd3);
    chk("R8", "rd_valid", {31'b0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "pin_oe after release", {24'b0, pin_oe}, 32'h0);

    set_mode(8'h01);
    chk("R4", "wr_ready when enabled and empty", {31'b0, wr_ready}, 32'd1);

    // Vector walk: R1, R2, R6
    for (int i = 0; i < NVEC; i++) begin
      rate_div = VEC[i][39:24];
      dir_mask = VEC[i][23:16];
      pin_in   = VEC[i][7:0];
      base = fall_count;
      write_byte(VEC[i][15:8]);
      wait_falls(base + 1);
      chk("R2", "pin_out after update", {24'b0, pin_out}, {24'b0, VEC[i][15:8]});
      chk("R1", "pin_oe follows dir_mask", {24'b0, pin_oe}, {24'b0, VEC[i][23:16]});
      repeat (4) @(negedge clk);
      do_read("R6", VEC[i][7:0]);
    end
    repeat (6) @(negedge clk);

    // R5: strobe timing across all updates so far
    chk("R5", "setup violations", setup_bad, 32'd0);
    chk("R5", "low width violations", width_bad, 32'd0);
    chk("R5", "hold violations", hold_bad, 32'd0);

    // R2: back-to-back bytes spaced by rate_div+1
    set_mode(8'h00);
    rate_div = 16'd49;
    set_mode(8'h01);
    base = fall_count;
    write_byte(8'h3A);
    write_byte(8'hC5);
    wait_falls(base + 2);
    chk("R2", "spacing of updates", fall_cyc_last - fall_cyc_prev, 32'd50);
    chk("R2", "second byte on pins", {24'b0, pin_out}, 32'hC5);

    // R3: no new byte means no change
    base = fall_count;
    repeat (300) @(negedge clk);
    chk("R3", "no strobe without data", fall_count, base);
    chk("R3", "pins hold last byte", {24'b0, pin_out}, 32'hC5);

    // R4: back-pressure, waiting byte kept
    set_mode(8'h00);
    rate_div = 16'd300;
    set_mode(8'h01);
    base = fall_count;
    write_byte(8'h11);
    chk("R4", "wr_ready low while full", {31'b0, wr_ready}, 32'd0);
    chk("R2", "no update before tick", {24'b0, pin_out}, 32'h00);
    wr_data  = 8'h22;
    wr_valid = 1'b1;
    repeat (50) @(negedge clk);
    chk("R4", "wr_ready stays low", {31'b0, wr_ready}, 32'd0);
    write_byte(8'h22);
    wait_falls(base + 1);
    chk("R4", "first byte kept", {24'b0, pin_out}, 32'h11);
    wait_falls(base + 2);
    chk("R4", "second byte follows", {24'b0, pin_out}, 32'h22);

    // R7: idle discards the waiting byte and quiets the port
    set_mode(8'h00);
    rate_div = 16'd60000;
    dir_mask = 8'hFF;
    set_mode(8'h01);
    write_byte(8'h99);
    set_mode(8'h00);
    @(negedge clk);
    chk("R7", "pin_out cleared", {24'b0, pin_out}, 32'h00);
    chk("R7", "pin_oe off", {24'b0, pin_oe}, 32'h00);
    chk("R7", "wr_ready low", {31'b0, wr_ready}, 32'd0);
    chk("R7", "strobes high", {30'b0, wr_strobe_n, rd_strobe_n}, 32'd3);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    base = 0;
    for (int k = 0; k < 6; k++) begin
      if (rd_valid || !rd_strobe_n) base++;
      @(negedge clk);
    end
    chk("R7", "read request while idle starts nothing", base, 32'd0);
    set_mode(8'h04);
    chk("R7", "mode 4 idles: wr_ready", {31'b0, wr_ready}, 32'd0);
    chk("R7", "mode 4 idles: pin_oe", {24'b0, pin_oe}, 32'h00);
    rate_div = 16'd2;
    set_mode(8'h00);
    base = fall_count;
    set_mode(8'h01);
    repeat (60) @(negedge clk);
    chk("R7", "discarded byte never appears", fall_count, base);
    chk("R7", "pins stay zero", {24'b0, pin_out}, 32'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule